// File: doc/BRIEF.md
# Two-Way Switch Lamp Controller

This block drives one lamp from two independent wall switches, in the way a stairway light can be worked from the top and from the bottom. Any change of level on either switch, up or down, inverts the lamp. Neither switch has a fixed "on" position, so the lamp can always be inverted from either place.

The switch inputs arrive with no timing relation to the system clock. Each one passes through its own multi-stage synchronizer. Each synchronized level is then compared with the value it had one clock earlier, which gives a one-cycle change pulse. The lamp is a single flip-flop that is inverted once for each change pulse. If both switches change in the same cycle, the two inversions cancel and the lamp keeps its value. The whole block runs on one clock with a synchronous active-high reset. There are no latches and no combinational loops. Contact bounce is assumed to have been removed before the inputs reach the block.

Top module: `twoway_lamp_ctrl`

## Requirements
- R1: While `rst_i` is high, and on the first cycle after it falls, `lamp_o` equals `RESET_LAMP` (default 0).
- R2: A rising level on `sw_a_i` inverts `lamp_o` once. If the input changes before rising clock edge n, the new lamp value appears after edge n+`SYNC_STAGES` (edge n+2 by default), and the old value holds through edge n+`SYNC_STAGES`-1.
- R3: A falling level on `sw_a_i` inverts `lamp_o` once.
- R4: A change of `sw_b_i` in either direction inverts `lamp_o` once.
- R5: When both switches change level in the same clock cycle, `lamp_o` keeps its value.
- R6: A switch that is already high while reset is applied causes no inversion after reset is released.
- R7: While neither switch changes, `lamp_o` holds its value on every cycle.
- R8: Changes of the two switches in consecutive clock cycles invert `lamp_o` on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sw_a_i | input | 1 | First switch level, asynchronous |
| sw_b_i | input | 1 | Second switch level, asynchronous |
| lamp_o | output | 1 | Registered lamp drive, 1 = on |

## Verification
The bench builds the block with its defaults: `SYNC_STAGES` = 2 and `RESET_LAMP` = 0. It computes the expected latency from `SYNC_STAGES`, so it checks the exact edge on which the lamp inverts and that the lamp holds on the edge before it. With two stages, a change of one switch can be placed one cycle after a change of the other. This shows the two inversions landing on neighbouring edges, and it also covers the case where both switches change together and cancel.

// File: rtl/lamp_ctrl_pkg.sv
package lamp_ctrl_pkg;
    localparam int unsigned SW_COUNT = 2;

    typedef struct packed {
        logic prev;
    } edge_state_t;

    typedef struct packed {
        logic lamp;
    } lamp_state_t;
endpackage

// File: rtl/lamp_sw_sync.sv
module lamp_sw_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = (chain_q << 1) | STAGES'(async_i);
    end

    always_ff @(posedge clk_i) begin
        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lamp_sw_edge.sv
module lamp_sw_edge
    import lamp_ctrl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    output logic change_o
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign change_o = rst_i ? 1'b0 : (level_i ^ st_q.prev);

    // R6
    change_tracks_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        change_o == !$stable(level_i));
endmodule

// File: rtl/lamp_toggle.sv
module lamp_toggle
    import lamp_ctrl_pkg::*;
#(
    parameter logic RESET_LAMP = 1'b0
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [SW_COUNT-1:0] change_i,
    output logic                lamp_o
);
    lamp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.lamp = RESET_LAMP;
        end else begin
            st_d.lamp = st_q.lamp ^ (^change_i);
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign lamp_o = st_q.lamp;

    // R1
    reset_value_chk: assert property (@(posedge clk_i)
        rst_i |=> lamp_o == RESET_LAMP);

    // R2
    single_change_flip_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (^change_i) |=> lamp_o != $past(lamp_o));

    // R5
    double_change_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (&change_i) |=> $stable(lamp_o));

    // R7
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(|change_i) |=> $stable(lamp_o));
endmodule

// File: rtl/twoway_lamp_ctrl.sv
module twoway_lamp_ctrl
    import lamp_ctrl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic        RESET_LAMP  = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic sw_a_i,
    input  logic sw_b_i,
    output logic lamp_o
);
    logic [SW_COUNT-1:0] sw_raw;
    logic [SW_COUNT-1:0] sw_sync;
    logic [SW_COUNT-1:0] sw_change;

    assign sw_raw = {sw_b_i, sw_a_i};

    for (genvar g = 0; g < SW_COUNT; g++) begin : g_switch
        lamp_sw_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk_i   (clk_i),
            .async_i (sw_raw[g]),
            .sync_o  (sw_sync[g])
        );

        lamp_sw_edge u_edge (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .level_i  (sw_sync[g]),
            .change_o (sw_change[g])
        );
    end

    lamp_toggle #(
        .RESET_LAMP (RESET_LAMP)
    ) u_toggle (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .change_i (sw_change),
        .lamp_o   (lamp_o)
    );
endmodule

// File: tb/twoway_lamp_ctrl_bench.sv
module twoway_lamp_ctrl_bench;
    localparam int unsigned SYNC_STAGES = 2;
    localparam logic        RESET_LAMP  = 1'b0;
    localparam int unsigned SETTLE      = SYNC_STAGES + 3;
    localparam int          NVEC        = 10;

    // each entry: {sw_b, sw_a, expected lamp after settling}
    localparam logic [2:0] VEC [NVEC] = '{
        3'b01_1,  // R2 a rises
        3'b00_0,  // R3 a falls
        3'b10_1,  // R4 b rises
        3'b00_0,  // R4 b falls
        3'b11_0,  // R5 both rise together
        3'b01_1,  // R4 b falls
        3'b11_0,  // R4 b rises
        3'b10_1,  // R3 a falls
        3'b01_1,  // R5 both change together
        3'b01_1   // R7 no change
    };
    localparam int VEC_REQ [NVEC] = '{2, 3, 4, 4, 5, 4, 4, 3, 5, 7};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] sw = 2'b00;
    logic lamp;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    twoway_lamp_ctrl #(
        .SYNC_STAGES (SYNC_STAGES),
        .RESET_LAMP  (RESET_LAMP)
    ) u_twoway_lamp_ctrl (
        .clk_i  (clk),
        .rst_i  (rst),
        .sw_a_i (sw[0]),
        .sw_b_i (sw[1]),
        .lamp_o (lamp)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: lamp=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        logic expl;
        // R1: reset value
        repeat (4) @(negedge clk);
        check("R1 during reset", lamp, RESET_LAMP);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", lamp, RESET_LAMP);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            sw = VEC[i][2:1];
            repeat (SETTLE) @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC_REQ[i], i), lamp, VEC[i][0]);
        end
        expl = lamp; // sw = 01, lamp = 1

        // R2: exact latency
        sw = 2'b00;
        for (int k = 0; k < int'(SYNC_STAGES); k++) begin
            @(negedge clk);
            check("R2 latency hold", lamp, expl);
        end
        @(negedge clk);
        check("R2 latency flip", lamp, ~expl);
        expl = ~expl;

        // R7: long idle
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check("R7 idle", lamp, expl);
        end

        // R8: a then b on consecutive cycles
        sw[0] = 1'b1;
        @(negedge clk);
        sw[1] = 1'b1;
        for (int k = 0; k < int'(SYNC_STAGES) - 1; k++) @(negedge clk);
        check("R8 before flips", lamp, expl);
        @(negedge clk);
        check("R8 first flip", lamp, ~expl);
        @(negedge clk);
        check("R8 second flip", lamp, expl);

        // R6: switches high across reset
        repeat (SETTLE) @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 reset again", lamp, RESET_LAMP);
        rst = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check("R6 no startup flip", lamp, RESET_LAMP);
        end
        sw[1] = 1'b0;
        repeat (SETTLE) @(negedge clk);
        check("R4 after reset", lamp, ~RESET_LAMP);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule